// File: doc/BRIEF.md
# Serial Character Record-and-Playback Buffer

This controller sits between a serial receiver and a serial transmitter. It keeps a small store of characters. Each byte the receiver delivers is written into an on-chip simple dual-port RAM. The same byte is sent straight back to the transmitter, so the user sees an echo. When the store holds its full capacity, a "full" status lights. From then on, incoming bytes are neither kept nor echoed.

A single-cycle playback request, already debounced and pulse-shaped upstream, starts playback. Playback replays the kept bytes to the transmitter in the order they arrived. It sends exactly as many bytes as were kept. After the last byte is handed over, the fill pointer returns to zero and the "empty" status lights. The RAM is not cleared; new bytes simply overwrite the old ones from position 0 upward.

The receive side is a one-cycle tick with its data, and it cannot be stalled. The transmit side is a valid/ready stream. A byte transfers on a clock edge where `tx_valid` and `tx_ready` are both high. Once `tx_valid` is raised, it stays high and `tx_data` stays constant until that transfer happens. The transmitter drives `tx_ready` high whenever it is not busy. The controller holds back each playback byte until the transmitter accepts it. During an echo, it cannot take a new byte until the pending echo has been accepted.

Top module: `rpb_buffer`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `tx_valid` is 0.
- R2: A receive tick in record mode, while the store is not full, no echo is pending and no playback starts in that cycle, keeps `rx_data` at the next fill position. In the cycle after the tick, `tx_valid` is 1, `tx_data` equals that byte and `empty` is 0.
- R3: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` keeps its value on the next cycle.
- R4: A receive tick that arrives while an echo is still waiting for `tx_ready` is dropped. That byte is neither kept nor echoed.
- R5: After DEPTH (32 by default) bytes are kept, `full` is 1. Further receive ticks are neither kept nor echoed.
- R6: A playback request in record mode, with at least one byte kept and no echo pending, sends the kept bytes in arrival order. It sends exactly as many bytes as were kept.
- R7: During playback, each byte waits on `tx_ready`. No byte is lost or repeated, whatever pattern `tx_ready` follows.
- R8: When the last playback byte is accepted, `empty` becomes 1 and `full` becomes 0. Later bytes are kept from position 0, so the next playback sends only those later bytes.
- R9: A playback request is ignored while the store is empty or while playback is running. Receive ticks that arrive during playback, or in the cycle playback starts, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle tick: a byte has been received |
| rx_data | input | 8 | Received byte, valid with `rx_valid` |
| play_req | input | 1 | One-cycle playback request |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter idle and accepting |
| tx_data | output | 8 | Byte offered to the transmitter |
| full | output | 1 | Store holds DEPTH bytes |
| empty | output | 1 | Store holds no bytes |

## Verification
The fill count is internal state, but a wrong count still shows at the ports. `full` or `empty` take the wrong value in the cycle after the tick that moved the count. A wrong count also makes a later playback send too many or too few bytes. A wrong read address or a missing fetch cycle shows up at the first playback transfer as a byte out of order or a repeated byte. A stuck echo flag shows up within one cycle of the next tick: `tx_valid` stays high after a transfer, or a following tick is wrongly dropped. The bench compares every transferred byte against its own list of what was sent in.

// File: rtl/rpb_pkg.sv
package rpb_pkg;

  // Controller operating phases
  typedef enum logic [1:0] {
    ST_REC   = 2'd0,  // recording: ticks are stored and echoed
    ST_FETCH = 2'd1,  // playback: read address issued, waiting RAM latency
    ST_SEND  = 2'd2   // playback: RAM byte offered on the transmit stream
  } rpb_state_e;

endpackage

// File: rtl/rpb_sdp_ram.sv
module rpb_sdp_ram #(
  parameter int WIDTH  = 8,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // Registered read, always enabled; a same-address write returns new data
  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr == rd_addr)) begin
      rd_data <= wr_data;
    end else begin
      rd_data <= mem[rd_addr];
    end
  end

  AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == rd_addr)) |=> (rd_data == $past(wr_data))); // R2

endmodule

// File: rtl/rpb_fill_tracker.sv
module rpb_fill_tracker #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              clr,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              full,
  output logic              empty
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc) begin
      count <= count + CNT_W'(1);
    end
  end

  assign wr_addr = count[ADDR_W-1:0];
  assign full    = (count == CNT_MAX);
  assign empty   = (count == '0);

  AST_INC_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> !empty); // R2
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && !full)); // R8

endmodule

// File: rtl/rpb_sequencer.sv
module rpb_sequencer
  import rpb_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [WIDTH-1:0]  rx_data,
  input  logic              play_req,
  input  logic              tx_ready,
  input  logic [CNT_W-1:0]  count,
  input  logic              full,
  output logic              wr_en,
  output logic              echo_busy,
  output logic [WIDTH-1:0]  echo_data,
  output logic              playing,
  output logic              sending,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              clr
);

  rpb_state_e state;
  logic       start;
  logic       last;
  logic       advance;

  assign start   = (state == ST_REC) && play_req && (count != '0) && !echo_busy;
  assign wr_en   = (state == ST_REC) && rx_valid && !full && !echo_busy && !start;
  assign sending = (state == ST_SEND);
  assign playing = (state != ST_REC);
  assign last    = ((CNT_W'(rd_addr) + CNT_W'(1)) == count);
  assign advance = sending && tx_ready;
  assign clr     = advance && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_REC;
      rd_addr <= '0;
    end else begin
      unique case (state)
        ST_REC: begin
          if (start) begin
            rd_addr <= '0;
            state   <= ST_FETCH;
          end
        end
        ST_FETCH: state <= ST_SEND;
        ST_SEND: begin
          if (advance) begin
            if (last) begin
              state <= ST_REC;
            end else begin
              rd_addr <= rd_addr + ADDR_W'(1);
              state   <= ST_FETCH;
            end
          end
        end
        default: state <= ST_REC;
      endcase
    end
  end

  // Echo holding register: raised on a stored tick, dropped on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      echo_busy <= 1'b0;
      echo_data <= '0;
    end else if (wr_en) begin
      echo_busy <= 1'b1;
      echo_data <= rx_data;
    end else if (tx_ready) begin
      echo_busy <= 1'b0;
    end
  end

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(playing) |-> ($past(count) != '0)); // R9
  AST_NO_ECHO_IN_PLAY: assert property (@(posedge clk) disable iff (!rst_n)
    playing |-> !echo_busy); // R9

endmodule

// File: rtl/rpb_buffer.sv
module rpb_buffer
  import rpb_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [WIDTH-1:0] rx_data,
  input  logic             play_req,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [WIDTH-1:0] tx_data,
  output logic             full,
  output logic             empty
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              wr_en;
  logic              clr;
  logic              echo_busy;
  logic              playing;
  logic              sending;
  logic [WIDTH-1:0]  echo_data;
  logic [WIDTH-1:0]  ram_q;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [CNT_W-1:0]  count;

  rpb_fill_tracker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fill (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (wr_en),
    .clr     (clr),
    .count   (count),
    .wr_addr (wr_addr),
    .full    (full),
    .empty   (empty)
  );

  rpb_sequencer #(.WIDTH(WIDTH), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .play_req  (play_req),
    .tx_ready  (tx_ready),
    .count     (count),
    .full      (full),
    .wr_en     (wr_en),
    .echo_busy (echo_busy),
    .echo_data (echo_data),
    .playing   (playing),
    .sending   (sending),
    .rd_addr   (rd_addr),
    .clr       (clr)
  );

  rpb_sdp_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (rx_data),
    .rd_addr (rd_addr),
    .rd_data (ram_q)
  );

  // Transmit source select: echo register in record mode, RAM in playback
  assign tx_valid = echo_busy || sending;
  assign tx_data  = playing ? ram_q : echo_data;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_en); // R5

endmodule

// File: tb/rpb_buffer_test.sv
module rpb_buffer_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       play_req = 1'b0;
  logic       tx_ready = 1'b1;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       full;
  logic       empty;

  int nchk = 0;
  int nfail = 0;
  int ncap = 0;
  logic [7:0] cap [256];

  rpb_buffer #(.WIDTH(8), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .play_req(play_req), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .full(full), .empty(empty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Transmitter model: records every byte that transfers on the next edge
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (ncap < 256) cap[ncap] = tx_data;
      ncap++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_data = b;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic pulse_play();
    @(posedge clk); #1;
    play_req = 1'b1;
    @(posedge clk); #1;
    play_req = 1'b0;
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (empty && !tx_valid) break;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(empty == 1'b1, "R1 empty", int'(empty), 1);
    chk(full == 1'b0, "R1 full", int'(full), 0);
    chk(tx_valid == 1'b0, "R1 tx_valid", int'(tx_valid), 0);
  endtask

  task automatic t_echo_and_play();
    ncap = 0; tx_ready = 1'b1;
    send_rx(8'h41);
    @(negedge clk);
    chk(tx_valid == 1'b1, "R2 echo valid", int'(tx_valid), 1);
    chk(tx_data == 8'h41, "R2 echo data", int'(tx_data), 'h41);
    chk(empty == 1'b0, "R2 empty low", int'(empty), 0);
    send_rx(8'h42);
    send_rx(8'h43);
    repeat (3) @(negedge clk);
    pulse_play();
    wait_empty();
    chk(ncap == 6, "R6 byte count", ncap, 6);
    for (int i = 0; i < 3; i++) begin
      chk(cap[i] == 8'(8'h41 + i), "R2 echo order", int'(cap[i]), 'h41 + i);
      chk(cap[3+i] == 8'(8'h41 + i), "R6 playback order", int'(cap[3+i]), 'h41 + i);
    end
    chk(empty == 1'b1 && full == 1'b0, "R8 empty after play", int'(empty), 1);
  endtask

  task automatic t_hold_and_drop();
    int bad;
    ncap = 0; tx_ready = 1'b0;
    send_rx(8'h55);
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!(tx_valid && tx_data == 8'h55)) bad++;
    end
    chk(bad == 0, "R3 held offer", bad, 0);
    send_rx(8'h66);
    @(negedge clk);
    chk(tx_data == 8'h55, "R4 pending echo kept", int'(tx_data), 'h55);
    @(posedge clk); #1 tx_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(ncap == 1 && cap[0] == 8'h55, "R4 single echo", ncap, 1);
    pulse_play();
    wait_empty();
    chk(ncap == 2, "R4 dropped byte not stored", ncap, 2);
    chk(cap[1] == 8'h55, "R4 playback data", int'(cap[1]), 'h55);
  endtask

  task automatic t_backpressure();
    int bad;
    tx_ready = 1'b1;
    for (int i = 0; i < 4; i++) send_rx(8'(8'hA0 + i));
    repeat (3) @(negedge clk);
    ncap = 0;
    fork
      begin
        pulse_play();
        wait_empty();
      end
      begin
        for (int i = 0; i < 40; i++) begin
          @(posedge clk); #1 tx_ready = ((i % 3) == 2);
        end
        tx_ready = 1'b1;
      end
    join
    chk(ncap == 4, "R7 count under stall", ncap, 4);
    bad = 0;
    for (int i = 0; i < 4; i++) if (cap[i] != 8'(8'hA0 + i)) bad++;
    chk(bad == 0, "R7 order under stall", bad, 0);
  endtask

  task automatic t_ignore_and_reuse();
    ncap = 0; tx_ready = 1'b1;
    pulse_play();
    repeat (8) @(negedge clk);
    chk(ncap == 0 && !tx_valid, "R9 play while empty", ncap, 0);
    chk(empty == 1'b1, "R9 still empty", int'(empty), 1);
    send_rx(8'h11);
    send_rx(8'h22);
    repeat (3) @(negedge clk);
    ncap = 0;
    @(posedge clk); #1 tx_ready = 1'b0;
    pulse_play();
    pulse_play();
    send_rx(8'h99);
    repeat (3) @(negedge clk);
    @(posedge clk); #1 tx_ready = 1'b1;
    wait_empty();
    chk(ncap == 2, "R9 single playback", ncap, 2);
    chk(cap[0] == 8'h11 && cap[1] == 8'h22, "R9 playback data", int'(cap[1]), 'h22);
    ncap = 0;
    pulse_play();
    repeat (8) @(negedge clk);
    chk(ncap == 0, "R9 tick in playback not stored", ncap, 0);
    send_rx(8'h77);
    repeat (3) @(negedge clk);
    ncap = 0;
    pulse_play();
    wait_empty();
    chk(ncap == 1 && cap[0] == 8'h77, "R8 restart at zero", ncap, 1);
  endtask

  task automatic t_full();
    int bad;
    ncap = 0; tx_ready = 1'b1;
    for (int i = 0; i < DEPTH; i++) send_rx(8'(i + 1));
    @(negedge clk);
    @(negedge clk);
    chk(full == 1'b1 && empty == 1'b0, "R5 full flag", int'(full), 1);
    chk(ncap == DEPTH, "R5 echoes while filling", ncap, DEPTH);
    send_rx(8'hC8);
    repeat (3) @(negedge clk);
    chk(ncap == DEPTH && !tx_valid, "R5 no echo when full", ncap, DEPTH);
    pulse_play();
    wait_empty();
    chk(ncap == 2 * DEPTH, "R5 playback count", ncap, 2 * DEPTH);
    bad = 0;
    for (int i = 0; i < DEPTH; i++) if (cap[DEPTH+i] != 8'(i + 1)) bad++;
    chk(bad == 0, "R6 full playback order", bad, 0);
    chk(full == 1'b0 && empty == 1'b1, "R8 flags after full play", int'(full), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_echo_and_play();
    t_hold_and_drop();
    t_backpressure();
    t_ignore_and_reuse();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule